// File: doc/BRIEF.md
# Transmit Bit-Repetition Oversampler

This block sits in front of a fixed-rate serializer and stretches slow video words to the line rate. Each accepted parallel word is expanded by repeating every bit N times. The repeated bits are packed, lowest bit first, into output words of the same width as the input. One input word therefore becomes exactly N output words, and one output word leaves on every clock. Input and output share a single clock. The source raises its valid strobe on roughly one cycle in N.

The factor N is picked at run time by a three-bit select. The select covers 1, 2, 4, 8, 11 and 44, which are the repetition counts that the supported video standards and transceiver rate modes call for. Because 11 and 44 do not divide the word width, a single output word can carry copies of two neighbouring input bits. An internal stream position (source bit index plus repetition phase) is therefore carried from word to word, in place of a simple shift.

Top module: `osr_tx_top`

## Requirements
- R1: The select maps 0→1, 1→2, 2→4, 3→8, 4→11 and 5→44 repetitions. Codes 6 and 7 behave as factor 1.
- R2: For an input word D accepted with factor N, output word k (k = 0..N-1) has bit j equal to D[floor((k·W + j)/N)], where W is the word width.
- R3: A word is accepted at a rising edge where the valid strobe is high and the block is either idle or showing the last word of the previous expansion. Output word 0 appears right after that edge, and each later edge advances by one word.
- R4: When no expansion is in progress, the output word is all zeros.
- R5: Valid asserted while the last output word of an expansion is shown starts the next expansion without a gap and does not raise overflow.
- R6: Valid asserted while an expansion is in progress, and not on its last word, is dropped. The running expansion continues unchanged, and the overflow output is high for exactly the one cycle after that edge.
- R7: The select is sampled only when a word is accepted. Changing it during an expansion has no effect on the words of that expansion.
- R8: Synchronous active-high reset abandons any expansion. From the next cycle the output is zero and overflow is low.
- R9: When N does not divide W, an output word can hold the tail copies of one input bit followed by the head copies of the next. With N=11 and W=20, word 0 carries D[0] in bits 0..10 and D[1] in bits 11..19.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for input and output words |
| rst | input | 1 | Synchronous reset, active high |
| fsel_i | input | 3 | Repetition factor select, sampled on acceptance |
| din_i | input | W | Parallel input word |
| din_valid_i | input | 1 | Input word strobe |
| dout_o | output | W | Oversampled output word, one per cycle |
| ovf_o | output | 1 | One-cycle pulse when a word is dropped |

## Verification
The hardest conditions to reach are the edges of an expansion window: a strobe on exactly the last shown word, which must chain seamlessly, versus one a cycle earlier, which must be dropped. The 44-word expansion at factor 44 makes that window wide enough to aim at a chosen interior word. The bench places strobes at chosen word indices inside the expansion: on the last word to chain, on an interior word to provoke a drop, and a select flip mid-expansion. Every select code is swept with several data patterns against an arithmetic model of the bit index.

// File: rtl/osr_pkg.sv
package osr_pkg;

    localparam int FW = 6;   // wide enough for the largest factor (44)
    localparam int PW = 8;   // source bit index width, word width up to 256

    typedef enum logic [2:0] {
        OSR_X1  = 3'd0,
        OSR_X2  = 3'd1,
        OSR_X4  = 3'd2,
        OSR_X8  = 3'd3,
        OSR_X11 = 3'd4,
        OSR_X44 = 3'd5
    } osr_sel_e;

    // Position inside the expanded bit stream at the start of an output word
    typedef struct packed {
        logic [PW-1:0] src;   // input bit currently being repeated
        logic [FW-1:0] rep;   // copies of that bit already emitted
    } osr_pos_t;

    function automatic logic [FW-1:0] factor_of(input logic [2:0] sel);
        case (sel)
            OSR_X2:  factor_of = FW'(2);
            OSR_X4:  factor_of = FW'(4);
            OSR_X8:  factor_of = FW'(8);
            OSR_X11: factor_of = FW'(11);
            OSR_X44: factor_of = FW'(44);
            default: factor_of = FW'(1);
        endcase
    endfunction

    // Division by the selected factor, written with constant divisors
    function automatic int unsigned div_fac(input int unsigned v, input logic [2:0] sel);
        case (sel)
            OSR_X2:  div_fac = v / 2;
            OSR_X4:  div_fac = v / 4;
            OSR_X8:  div_fac = v / 8;
            OSR_X11: div_fac = v / 11;
            OSR_X44: div_fac = v / 44;
            default: div_fac = v;
        endcase
    endfunction

endpackage

// File: rtl/osr_ctrl.sv
module osr_ctrl
    import osr_pkg::*;
#(
    parameter int W = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [2:0]    sel_i,
    input  logic [W-1:0]  data_i,
    output logic [W-1:0]  hold_o,
    output logic [2:0]    sel_o,
    output osr_pos_t      pos_o,
    output logic          busy_o,
    output logic          last_o,
    output logic          ovf_o
);

    logic [FW-1:0] n_q;
    logic [FW-1:0] k_q;
    osr_pos_t      pos_nxt;
    logic          accept;

    assign last_o = busy_o && (k_q == n_q - FW'(1));
    assign accept = valid_i && (!busy_o || last_o);

    always_comb begin
        int unsigned t;
        int unsigned q;
        t = int'(pos_o.rep) + W;
        q = div_fac(t, sel_o);
        pos_nxt.rep = FW'(t - q * int'(n_q));
        pos_nxt.src = pos_o.src + PW'(q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o <= '0;
            sel_o  <= '0;
            n_q    <= FW'(1);
            k_q    <= '0;
            pos_o  <= '0;
            busy_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            ovf_o <= valid_i && busy_o && !last_o;
            if (accept) begin
                hold_o <= data_i;
                sel_o  <= sel_i;
                n_q    <= factor_of(sel_i);
                k_q    <= '0;
                pos_o  <= '0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (last_o) begin
                    busy_o <= 1'b0;
                end else begin
                    k_q   <= k_q + FW'(1);
                    pos_o <= pos_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/osr_pack.sv
module osr_pack
    import osr_pkg::*;
#(
    parameter int W = 20
) (
    input  logic [W-1:0] hold_i,
    input  logic [2:0]   sel_i,
    input  osr_pos_t     pos_i,
    input  logic         busy_i,
    output logic [W-1:0] word_o
);

    localparam int SW = (W > 1) ? $clog2(W) : 1;

    for (genvar j = 0; j < W; j++) begin : g_bit
        always_comb begin
            int unsigned off;
            int unsigned src;
            off = int'(pos_i.rep) + j;
            src = int'(pos_i.src) + div_fac(off, sel_i);
            word_o[j] = 1'b0;
            if (busy_i && src < W)
                word_o[j] = hold_i[SW'(src)];
        end
    end

endmodule

// File: rtl/osr_tx_top.sv
module osr_tx_top
    import osr_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   fsel_i,
    input  logic [W-1:0] din_i,
    input  logic         din_valid_i,
    output logic [W-1:0] dout_o,
    output logic         ovf_o
);

    logic [W-1:0] hold;
    logic [2:0]   sel_q;
    osr_pos_t     pos;
    logic         busy;
    logic         last;

    osr_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .valid_i (din_valid_i),
        .sel_i   (fsel_i),
        .data_i  (din_i),
        .hold_o  (hold),
        .sel_o   (sel_q),
        .pos_o   (pos),
        .busy_o  (busy),
        .last_o  (last),
        .ovf_o   (ovf_o)
    );

    osr_pack #(.W(W)) u_pack (
        .hold_i (hold),
        .sel_i  (sel_q),
        .pos_i  (pos),
        .busy_i (busy),
        .word_o (dout_o)
    );

endmodule

// File: rtl/osr_tx_chk.sv
module osr_tx_chk #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst,
    input logic         valid,
    input logic [2:0]   sel,
    input logic [W-1:0] din,
    input logic [W-1:0] dout,
    input logic         ovf,
    input logic         busy,
    input logic         last,
    input logic [W-1:0] hold,
    input logic [2:0]   sel_q
);

    a_r8_reset_clears: assert property (@(posedge clk) rst |=> (dout == '0 && !ovf));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst) !busy |-> dout == '0);

    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(valid) && $past(busy) && !$past(last));

    a_r6_drop_keeps_word: assert property (@(posedge clk) disable iff (rst)
        (valid && busy && !last) |=> $stable(hold) && ovf);

    a_r7_sel_latched: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> $stable(sel_q));

    a_r1_unity_passthru: assert property (@(posedge clk) disable iff (rst)
        (valid && (!busy || last) && sel == 3'd0) |=> dout == $past(din));

    a_r5_chain_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (valid && last) |=> !ovf && busy);

endmodule

bind osr_tx_top osr_tx_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .valid (din_valid_i),
    .sel   (fsel_i),
    .din   (din_i),
    .dout  (dout_o),
    .ovf   (ovf_o),
    .busy  (busy),
    .last  (last),
    .hold  (hold),
    .sel_q (sel_q)
);

// File: tb/osr_tx_top_tb.sv
module osr_tx_top_tb;

    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   fsel = 3'd0;
    logic [W-1:0] din = '0;
    logic         dvalid = 1'b0;
    logic [W-1:0] dout;
    logic         ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    osr_tx_top #(.W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .fsel_i      (fsel),
        .din_i       (din),
        .din_valid_i (dvalid),
        .dout_o      (dout),
        .ovf_o       (ovf)
    );

    function automatic int fac(input int s);
        case (s)
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 11;
            5: return 44;
            default: return 1;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] d, input int n, input int k);
        logic [W-1:0] r;
        for (int j = 0; j < W; j++) r[j] = d[(k * W + j) / n];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start(input logic [2:0] s, input logic [W-1:0] d);
        fsel = s;
        din = d;
        dvalid = 1'b1;
    endtask

    // Called at the negedge where a word has just been driven with valid
    task automatic expand(input logic [W-1:0] d, input int n, input int inj, input int chg,
                          input bit chain, input logic [W-1:0] nd, input logic [2:0] ns);
        for (int k = 0; k < n; k++) begin
            logic [W-1:0] e;
            @(negedge clk);
            if (k == 0) dvalid = 1'b0;
            if (k == inj + 1) dvalid = 1'b0;
            e = exp_word(d, n, k);
            chk(dout == e, "R2 word content", dout, e);
            chk(ovf == ((inj >= 0) && (k == inj + 1)), "R6 overflow flag",
                W'(ovf), W'((inj >= 0) && (k == inj + 1)));
            if (k == inj) begin
                dvalid = 1'b1;
                din = ~d;
            end
            if (k == chg) fsel = fsel ^ 3'b101;
            if (k == n - 1 && chain) start(ns, nd);
        end
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk(dout == '0, "R4 idle zero", dout, '0);
        chk(!ovf, "R4 idle no overflow", W'(ovf), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dout == '0, "R8 reset output", dout, '0);
        chk(!ovf, "R8 reset overflow", W'(ovf), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(dout == '0, "R4 idle after reset", dout, '0);

        // R1/R2/R3: sweep every select code with several patterns
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 4; p++) begin
                logic [W-1:0] d;
                d = W'(32'h9E3779B9 * (s * 4 + p + 1));
                if (p == 0) d = 20'hAAAAA;
                start(3'(s), d);
                expand(d, fac(s), -1, -1, 1'b0, '0, 3'd0);
                idle_chk();
            end
        end

        // R9: straddling bits with factor 11
        start(3'd4, 20'h00002);
        @(negedge clk);
        dvalid = 1'b0;
        chk(dout == 20'hFF800, "R9 straddle word 0", dout, 20'hFF800);
        repeat (11) @(negedge clk);
        chk(dout == '0, "R4 idle after R9", dout, '0);

        // R5: chained expansions, factor 11 then 4 then 1
        start(3'd4, 20'h3C5A1);
        expand(20'h3C5A1, 11, -1, -1, 1'b1, 20'h81F07, 3'd2);
        expand(20'h81F07, 4, -1, -1, 1'b1, 20'h5E3B2, 3'd0);
        expand(20'h5E3B2, 1, -1, -1, 1'b0, '0, 3'd0);
        idle_chk();

        // R6: drop inside a long factor-44 expansion
        start(3'd5, 20'hC3A96);
        expand(20'hC3A96, 44, 7, -1, 1'b0, '0, 3'd0);
        idle_chk();
        start(3'd3, 20'h1F2E3);
        expand(20'h1F2E3, 8, 0, -1, 1'b0, '0, 3'd0);
        idle_chk();

        // R7: select flips mid-expansion
        start(3'd3, 20'h6B7D1);
        expand(20'h6B7D1, 8, -1, 2, 1'b0, '0, 3'd0);
        idle_chk();
        start(3'd4, 20'hF00F5);
        expand(20'hF00F5, 11, -1, 5, 1'b0, '0, 3'd0);
        idle_chk();

        // R8: reset during expansion
        start(3'd5, 20'hFFFFF);
        @(negedge clk);
        dvalid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(dout == '0, "R8 reset mid-expansion", dout, '0);
        chk(!ovf, "R8 reset mid overflow", W'(ovf), '0);
        rst = 1'b0;
        @(negedge clk);
        chk(dout == '0, "R8 expansion abandoned", dout, '0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule